// File: doc/BRIEF.md
# Audio Sample FIFO Pair with Watermark Requests

This block sits between a processor-side register port and a serial audio shifter. It holds two 16-entry FIFOs of 32-bit words: one carries samples toward the shifter (transmit) and one carries samples captured by the shifter back to the processor (receive). Each FIFO compares its fill state against a coarse programmable watermark, in steps of four slots, and raises an attention request. Each request has its own interrupt-enable gate. The transmit side reports how many slots are free, so software can size its next burst of writes.

Processor words can be repacked according to a word-format code. In the single-sample format, one word is one sample. In the paired format, one word carries two 16-bit samples. A bus sample-size selection zero-fills the low-order bits that the serial bus does not carry, in both directions. Each FIFO has its own clear strobe. A clear wins over any push or pop in the same cycle. Writes into a full transmit FIFO and reads from an empty receive FIFO are dropped, and each raises a sticky error flag.

Top module: `audio_sample_fifos`

## Requirements
- R1: After reset both FIFOs are empty, `tx_free` is 16, both attention requests and both interrupts are low, both error flags are low, `tx_sample_valid` is low and `cpu_rd_data` is zero.
- R2: Word-format codes 0 to 3 select the single-sample format. Each processor write stores one word, and that word is presented whole as one transmit sample. Each received sample becomes one word that can be read.
- R3: Word-format codes 4 to 7 select the paired format.
  - Transmit: a written word yields two samples. Bits [15:0] come first and bits [31:16] second, each placed in sample bits [31:16] with bits [15:0] zero. The word leaves the FIFO after its second sample.
  - Receive: the first sample's bits [31:16] become word bits [15:0], and the second sample's bits [31:16] become word bits [31:16]. The word is stored after the second sample.
- R4: `bus_size` value 0 (16-bit) forces sample bits [15:0] to zero, and value 1 (24-bit) forces bits [7:0] to zero. Values 2 and 3 (32-bit) pass all bits. This applies to transmit samples and to received samples before they are stored.
- R5: `tx_free` equals 16 minus the transmit FIFO occupancy. It changes on the clock edge that accepts a write or removes a word.
- R6: `tx_attn` is high exactly when `tx_level` is nonzero and `tx_free` is at least 4 × `tx_level`.
- R7: `rx_attn` is high exactly when `rx_level` is nonzero and the receive occupancy is at least 4 × `rx_level`.
- R8: `tx_irq` equals `tx_attn` AND `tx_irq_en`, and `rx_irq` equals `rx_attn` AND `rx_irq_en`.
- R9: A clear strobe empties only its own FIFO, within one cycle. A push or pop in the same cycle is discarded. The clear also restarts that direction's paired-format half sequence.
- R10: A write into a full transmit FIFO is dropped and sets `tx_overflow`. A read from an empty receive FIFO is dropped, returns zero and sets `rx_underflow`. Each flag stays set until its own clear strobe. A received sample arriving while the receive FIFO is full is dropped.
- R11: `tx_sample_valid` is high exactly when the transmit FIFO holds a word. A `tx_sample_req` while it is low changes nothing, and `tx_sample` is zero then.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cpu_wr_en | input | 1 | Push one word into the transmit FIFO |
| cpu_wr_data | input | 32 | Word to push |
| cpu_rd_en | input | 1 | Pop one word from the receive FIFO |
| cpu_rd_data | output | 32 | Head word of the receive FIFO, zero when empty |
| tx_clear | input | 1 | Flush the transmit FIFO and clear `tx_overflow` |
| rx_clear | input | 1 | Flush the receive FIFO and clear `rx_underflow` |
| tx_level | input | 2 | Transmit watermark in units of 4 free slots, 0 disables |
| rx_level | input | 2 | Receive watermark in units of 4 filled slots, 0 disables |
| tx_irq_en | input | 1 | Gate for `tx_irq` |
| rx_irq_en | input | 1 | Gate for `rx_irq` |
| word_fmt | input | 3 | Word format: 0-3 single sample, 4-7 two 16-bit samples |
| bus_size | input | 2 | Bus sample size: 0 16-bit, 1 24-bit, 2-3 32-bit |
| tx_sample_req | input | 1 | Shifter consumes the presented transmit sample |
| tx_sample | output | 32 | Transmit sample, MSB-aligned |
| tx_sample_valid | output | 1 | Transmit sample available |
| rx_sample_valid | input | 1 | Shifter delivers a received sample |
| rx_sample | input | 32 | Received sample, MSB-aligned |
| tx_free | output | 7 | Free transmit slots |
| tx_attn | output | 1 | Transmit watermark request |
| rx_attn | output | 1 | Receive watermark request |
| tx_irq | output | 1 | Gated transmit request |
| rx_irq | output | 1 | Gated receive request |
| tx_overflow | output | 1 | Sticky: write dropped on full FIFO |
| rx_underflow | output | 1 | Sticky: read dropped on empty FIFO |

## Verification
On every cycle, the assertions check the following:
- occupancy stays within bounds;
- a clear leaves its FIFO empty on the next edge and leaves the other FIFO alone;
- pushes on full and pops on empty change nothing;
- the error flags set and hold as specified;
- the interrupts never rise without their enable;
- the repacking stages only pop or push when data exists.

Only the bench scenarios can show the following:
- the exact data order of the paired format;
- the zero-fill of each bus size across every format code;
- the watermark thresholds at every occupancy and every level;
- that a clear restarts a half-consumed word.

// File: rtl/afifo_pkg.sv
package afifo_pkg;

    localparam int SAMPLE_W   = 32;
    localparam int HALF_W     = SAMPLE_W / 2;
    localparam int BYTE_W     = 8;

    typedef logic [SAMPLE_W-1:0] sample_t;
    typedef logic [HALF_W-1:0]   half_t;

    // Sticky error state held by the top level.
    typedef struct packed {
        logic tx_ovf;
        logic rx_unf;
    } err_state_t;

    // Bits the serial bus carries, MSB-aligned; missing low bits read as zero.
    function automatic sample_t size_mask(input logic [1:0] sz);
        sample_t m;
        case (sz)
            2'd0:    m = {{HALF_W{1'b1}}, {HALF_W{1'b0}}};
            2'd1:    m = {{(SAMPLE_W-BYTE_W){1'b1}}, {BYTE_W{1'b0}}};
            default: m = {SAMPLE_W{1'b1}};
        endcase
        return m;
    endfunction

    // Format codes from 4 upward pack two half-width samples per word.
    function automatic logic paired_format(input logic [2:0] code);
        return code[2];
    endfunction

endpackage

// File: rtl/afifo_store.sv
module afifo_store #(
    parameter int DEPTH = 16,
    parameter int W     = 32,
    parameter int CNT_W = $clog2(DEPTH + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clear,
    input  logic             push,
    input  logic [W-1:0]     push_data,
    input  logic             pop,
    output logic [W-1:0]     head,
    output logic [CNT_W-1:0] count,
    output logic             full,
    output logic             empty
);

    localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam logic [PTR_W-1:0] LAST_PTR = PTR_W'(DEPTH - 1);
    localparam logic [CNT_W-1:0] FULL_CNT = CNT_W'(DEPTH);

    typedef struct packed {
        logic [PTR_W-1:0] wr;
        logic [PTR_W-1:0] rd;
        logic [CNT_W-1:0] cnt;
    } store_state_t;

    store_state_t st_q, st_d;
    logic [W-1:0] mem_q [DEPTH];
    logic do_push, do_pop;

    function automatic logic [PTR_W-1:0] ptr_next(input logic [PTR_W-1:0] p);
        return (p == LAST_PTR) ? '0 : p + 1'b1;
    endfunction

    assign full  = (st_q.cnt == FULL_CNT);
    assign empty = (st_q.cnt == '0);
    assign count = st_q.cnt;
    assign head  = mem_q[st_q.rd];

    always_comb begin
        do_push = push && !full && !clear;
        do_pop  = pop && !empty && !clear;
        st_d    = st_q;
        if (clear) begin
            st_d = '0;
        end else begin
            if (do_push) st_d.wr = ptr_next(st_q.wr);
            if (do_pop)  st_d.rd = ptr_next(st_q.rd);
            case ({do_push, do_pop})
                2'b10:   st_d.cnt = st_q.cnt + 1'b1;
                2'b01:   st_d.cnt = st_q.cnt - 1'b1;
                default: st_d.cnt = st_q.cnt;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    always_ff @(posedge clk) begin
        if (do_push) mem_q[st_q.wr] <= push_data;
    end

    AST_COUNT_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        count <= FULL_CNT); // R5
    AST_CLEAR_EMPTIES: assert property (@(posedge clk) disable iff (!rst_n)
        clear |=> empty); // R9
    AST_FULL_PUSH_DROPPED: assert property (@(posedge clk) disable iff (!rst_n)
        (full && push && !pop && !clear) |=> full); // R10
    AST_EMPTY_POP_DROPPED: assert property (@(posedge clk) disable iff (!rst_n)
        (empty && pop && !push && !clear) |=> empty); // R10

endmodule

// File: rtl/afifo_tx_split.sv
module afifo_tx_split
    import afifo_pkg::*;
(
    input  logic      clk,
    input  logic      rst_n,
    input  logic      clear,
    input  logic      half_mode,
    input  logic [1:0] bus_sz,
    input  sample_t   head,
    input  logic      empty,
    input  logic      sample_req,
    output sample_t   sample,
    output logic      sample_valid,
    output logic      pop
);

    typedef struct packed {
        logic upper; // next half to send is bits [31:16]
    } split_state_t;

    split_state_t st_q, st_d;
    sample_t raw;
    logic take;

    always_comb begin
        st_d = st_q;
        if (half_mode) begin
            raw = st_q.upper ? {head[SAMPLE_W-1:HALF_W], {HALF_W{1'b0}}}
                             : {head[HALF_W-1:0], {HALF_W{1'b0}}};
        end else begin
            raw = head;
        end
        sample_valid = !empty;
        sample       = empty ? '0 : (raw & size_mask(bus_sz));
        take         = sample_req && !empty;
        pop          = take && (!half_mode || st_q.upper);
        if (clear) begin
            st_d.upper = 1'b0;
        end else if (take) begin
            st_d.upper = half_mode && !st_q.upper;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    AST_SPLIT_POP_NONEMPTY: assert property (@(posedge clk) disable iff (!rst_n)
        pop |-> !empty); // R11
    AST_SPLIT_SINGLE_POPS: assert property (@(posedge clk) disable iff (!rst_n)
        (!half_mode && sample_req && !empty) |-> pop); // R2
    AST_SPLIT_CLEAR_PHASE: assert property (@(posedge clk) disable iff (!rst_n)
        clear |=> !st_q.upper); // R9

endmodule

// File: rtl/afifo_rx_join.sv
module afifo_rx_join
    import afifo_pkg::*;
(
    input  logic      clk,
    input  logic      rst_n,
    input  logic      clear,
    input  logic      half_mode,
    input  logic [1:0] bus_sz,
    input  logic      in_valid,
    input  sample_t   in_sample,
    output logic      push,
    output sample_t   push_data
);

    typedef struct packed {
        logic  second; // one half already held
        half_t hold;
    } join_state_t;

    join_state_t st_q, st_d;
    sample_t masked;

    always_comb begin
        st_d      = st_q;
        masked    = in_sample & size_mask(bus_sz);
        push      = 1'b0;
        push_data = masked;
        if (half_mode) begin
            push_data = {masked[SAMPLE_W-1:HALF_W], st_q.hold};
            if (in_valid) begin
                if (st_q.second) begin
                    push        = 1'b1;
                    st_d.second = 1'b0;
                end else begin
                    st_d.hold   = masked[SAMPLE_W-1:HALF_W];
                    st_d.second = 1'b1;
                end
            end
        end else begin
            push        = in_valid;
            st_d.second = 1'b0;
        end
        if (clear) st_d.second = 1'b0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    AST_JOIN_PUSH_NEEDS_SAMPLE: assert property (@(posedge clk) disable iff (!rst_n)
        push |-> in_valid); // R3
    AST_JOIN_CLEAR_PHASE: assert property (@(posedge clk) disable iff (!rst_n)
        clear |=> !st_q.second); // R9

endmodule

// File: rtl/audio_sample_fifos.sv
module audio_sample_fifos
    import afifo_pkg::*;
#(
    parameter int DEPTH   = 16,
    parameter int WM_STEP = 4,
    parameter int FREE_W  = 7
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cpu_wr_en,
    input  logic [31:0]       cpu_wr_data,
    input  logic              cpu_rd_en,
    output logic [31:0]       cpu_rd_data,
    input  logic              tx_clear,
    input  logic              rx_clear,
    input  logic [1:0]        tx_level,
    input  logic [1:0]        rx_level,
    input  logic              tx_irq_en,
    input  logic              rx_irq_en,
    input  logic [2:0]        word_fmt,
    input  logic [1:0]        bus_size,
    input  logic              tx_sample_req,
    output logic [31:0]       tx_sample,
    output logic              tx_sample_valid,
    input  logic              rx_sample_valid,
    input  logic [31:0]       rx_sample,
    output logic [FREE_W-1:0] tx_free,
    output logic              tx_attn,
    output logic              rx_attn,
    output logic              tx_irq,
    output logic              rx_irq,
    output logic              tx_overflow,
    output logic              rx_underflow
);

    localparam int CNT_W = $clog2(DEPTH + 1);
    localparam logic [FREE_W-1:0] DEPTH_F = FREE_W'(DEPTH);
    localparam logic [FREE_W-1:0] STEP_F  = FREE_W'(WM_STEP);

    err_state_t err_q, err_d;

    logic             half_mode;
    logic             tx_pop, tx_full, tx_empty;
    logic             rx_push, rx_full, rx_empty;
    sample_t          tx_head, rx_head, rx_push_data;
    logic [CNT_W-1:0] tx_count, rx_count;
    logic [FREE_W-1:0] tx_mark, rx_mark, rx_fill;

    assign half_mode = paired_format(word_fmt);

    afifo_store #(.DEPTH(DEPTH), .W(SAMPLE_W)) u_tx_store (
        .clk       (clk),
        .rst_n     (rst_n),
        .clear     (tx_clear),
        .push      (cpu_wr_en),
        .push_data (cpu_wr_data),
        .pop       (tx_pop),
        .head      (tx_head),
        .count     (tx_count),
        .full      (tx_full),
        .empty     (tx_empty)
    );

    afifo_tx_split u_tx_split (
        .clk          (clk),
        .rst_n        (rst_n),
        .clear        (tx_clear),
        .half_mode    (half_mode),
        .bus_sz       (bus_size),
        .head         (tx_head),
        .empty        (tx_empty),
        .sample_req   (tx_sample_req),
        .sample       (tx_sample),
        .sample_valid (tx_sample_valid),
        .pop          (tx_pop)
    );

    afifo_rx_join u_rx_join (
        .clk       (clk),
        .rst_n     (rst_n),
        .clear     (rx_clear),
        .half_mode (half_mode),
        .bus_sz    (bus_size),
        .in_valid  (rx_sample_valid),
        .in_sample (rx_sample),
        .push      (rx_push),
        .push_data (rx_push_data)
    );

    afifo_store #(.DEPTH(DEPTH), .W(SAMPLE_W)) u_rx_store (
        .clk       (clk),
        .rst_n     (rst_n),
        .clear     (rx_clear),
        .push      (rx_push),
        .push_data (rx_push_data),
        .pop       (cpu_rd_en),
        .head      (rx_head),
        .count     (rx_count),
        .full      (rx_full),
        .empty     (rx_empty)
    );

    always_comb begin
        err_d = err_q;
        if (tx_clear)                    err_d.tx_ovf = 1'b0;
        else if (cpu_wr_en && tx_full)   err_d.tx_ovf = 1'b1;
        if (rx_clear)                    err_d.rx_unf = 1'b0;
        else if (cpu_rd_en && rx_empty)  err_d.rx_unf = 1'b1;

        tx_free = DEPTH_F - FREE_W'(tx_count);
        rx_fill = FREE_W'(rx_count);
        tx_mark = FREE_W'(tx_level) * STEP_F;
        rx_mark = FREE_W'(rx_level) * STEP_F;
        tx_attn = (tx_level != 2'd0) && (tx_free >= tx_mark);
        rx_attn = (rx_level != 2'd0) && (rx_fill >= rx_mark);
        tx_irq  = tx_attn && tx_irq_en;
        rx_irq  = rx_attn && rx_irq_en;

        cpu_rd_data  = rx_empty ? '0 : rx_head;
        tx_overflow  = err_q.tx_ovf;
        rx_underflow = err_q.rx_unf;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) err_q <= '0;
        else        err_q <= err_d;
    end

    AST_TX_OVF_SETS: assert property (@(posedge clk) disable iff (!rst_n)
        (cpu_wr_en && tx_full && !tx_clear) |=> tx_overflow); // R10
    AST_TX_OVF_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_overflow && !tx_clear) |=> tx_overflow); // R10
    AST_RX_UNF_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_underflow && !rx_clear) |=> rx_underflow); // R10
    AST_TX_IRQ_GATED: assert property (@(posedge clk) disable iff (!rst_n)
        tx_irq |-> tx_irq_en); // R8
    AST_RX_IRQ_GATED: assert property (@(posedge clk) disable iff (!rst_n)
        rx_irq |-> rx_irq_en); // R8
    AST_TX_CLEAR_ISOLATED: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_clear && !rx_clear && !rx_push && !cpu_rd_en) |=> $stable(rx_count)); // R9
    AST_RX_CLEAR_ISOLATED: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_clear && !tx_clear && !cpu_wr_en && !tx_pop) |=> $stable(tx_count)); // R9
    AST_FREE_ON_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
        tx_clear |=> (tx_free == DEPTH_F)); // R5

endmodule

// File: tb/test_audio_sample_fifos.sv
`timescale 1ns/1ps
module test_audio_sample_fifos;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cpu_wr_en = 1'b0;
    logic [31:0] cpu_wr_data = '0;
    logic        cpu_rd_en = 1'b0;
    logic [31:0] cpu_rd_data;
    logic        tx_clear = 1'b0;
    logic        rx_clear = 1'b0;
    logic [1:0]  tx_level = 2'd0;
    logic [1:0]  rx_level = 2'd0;
    logic        tx_irq_en = 1'b0;
    logic        rx_irq_en = 1'b0;
    logic [2:0]  word_fmt = 3'd3;
    logic [1:0]  bus_size = 2'd2;
    logic        tx_sample_req = 1'b0;
    logic [31:0] tx_sample;
    logic        tx_sample_valid;
    logic        rx_sample_valid = 1'b0;
    logic [31:0] rx_sample = '0;
    logic [6:0]  tx_free;
    logic        tx_attn, rx_attn, tx_irq, rx_irq, tx_overflow, rx_underflow;

    int compared = 0;
    int mismatched = 0;
    logic done = 1'b0;

    always #5 clk = ~clk;

    audio_sample_fifos i_audio_sample_fifos (
        .clk(clk), .rst_n(rst_n),
        .cpu_wr_en(cpu_wr_en), .cpu_wr_data(cpu_wr_data),
        .cpu_rd_en(cpu_rd_en), .cpu_rd_data(cpu_rd_data),
        .tx_clear(tx_clear), .rx_clear(rx_clear),
        .tx_level(tx_level), .rx_level(rx_level),
        .tx_irq_en(tx_irq_en), .rx_irq_en(rx_irq_en),
        .word_fmt(word_fmt), .bus_size(bus_size),
        .tx_sample_req(tx_sample_req), .tx_sample(tx_sample),
        .tx_sample_valid(tx_sample_valid),
        .rx_sample_valid(rx_sample_valid), .rx_sample(rx_sample),
        .tx_free(tx_free), .tx_attn(tx_attn), .rx_attn(rx_attn),
        .tx_irq(tx_irq), .rx_irq(rx_irq),
        .tx_overflow(tx_overflow), .rx_underflow(rx_underflow)
    );

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        compared++;
        if (!ok) begin
            mismatched++;
            $display("FAIL %s actual=%h expected=%h at %0t", req, act, exp, $time);
        end
    endtask

    task automatic step();
        @(negedge clk);
    endtask

    task automatic cpu_write(input logic [31:0] d);
        cpu_wr_en = 1'b1; cpu_wr_data = d; step(); cpu_wr_en = 1'b0;
    endtask

    task automatic cpu_read(output logic [31:0] d);
        d = cpu_rd_data; cpu_rd_en = 1'b1; step(); cpu_rd_en = 1'b0;
    endtask

    task automatic tx_take(output logic [31:0] s);
        s = tx_sample; tx_sample_req = 1'b1; step(); tx_sample_req = 1'b0;
    endtask

    task automatic rx_put(input logic [31:0] s);
        rx_sample_valid = 1'b1; rx_sample = s; step(); rx_sample_valid = 1'b0;
    endtask

    function automatic logic [31:0] bmask(input int b);
        int z;
        z = (b == 0) ? 16 : ((b == 1) ? 8 : 0);
        return 32'hFFFF_FFFF << z;
    endfunction

    function automatic bit exp_attn(input int lvl, input int n);
        return (lvl != 0) && (n >= 4 * lvl);
    endfunction

    initial begin
        #2_000_000;
        if (!done) begin
            compared++; mismatched++;
            $display("FAIL watchdog expired actual=running expected=finished");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
            $finish;
        end
    end

    initial begin
        logic [31:0] v;
        logic [31:0] w;
        logic [15:0] lo, hi;
        step(); step();
        rst_n = 1'b1;
        step();

        // R1: reset state
        tx_level = 2'd1; rx_level = 2'd1; tx_irq_en = 1'b1; rx_irq_en = 1'b1;
        #0.2;
        chk(tx_free == 7'd16, "R1 tx_free", 32'(tx_free), 32'd16);
        chk(!rx_attn && !rx_irq, "R1 rx_attn", 32'(rx_attn), 32'd0);
        chk(!tx_overflow && !rx_underflow, "R1 flags", {30'd0, tx_overflow, rx_underflow}, 32'd0);
        chk(!tx_sample_valid && tx_sample == 32'd0, "R1 tx_sample", tx_sample, 32'd0);
        chk(cpu_rd_data == 32'd0, "R1 rd_data", cpu_rd_data, 32'd0);
        tx_irq_en = 1'b0;
        #0.2;
        chk(tx_attn && !tx_irq, "R8 irq gated off", 32'(tx_irq), 32'd0);
        tx_irq_en = 1'b1;
        step();

        // R5 R6 R8: transmit fill sweep over all levels
        word_fmt = 3'd3; bus_size = 2'd2;
        for (int k = 0; k <= 16; k++) begin
            chk(tx_free == 7'(16 - k), "R5 tx_free", 32'(tx_free), 32'(16 - k));
            for (int lvl = 0; lvl < 4; lvl++) begin
                tx_level = 2'(lvl);
                #0.2;
                chk(tx_attn == exp_attn(lvl, 16 - k), "R6 tx_attn", 32'(tx_attn), 32'(exp_attn(lvl, 16 - k)));
                chk(tx_irq == exp_attn(lvl, 16 - k), "R8 tx_irq", 32'(tx_irq), 32'(exp_attn(lvl, 16 - k)));
            end
            step();
            if (k < 16) cpu_write(32'hA500_0000 + 32'(k * 32'h0101));
        end
        // R10: write on full is dropped and flagged
        cpu_write(32'hDEAD_BEEF);
        chk(tx_overflow, "R10 tx_overflow", 32'(tx_overflow), 32'd1);
        chk(tx_free == 7'd0, "R10 full write dropped", 32'(tx_free), 32'd0);

        // R2 R11: drain in order
        for (int k = 0; k < 16; k++) begin
            chk(tx_sample_valid, "R11 valid", 32'(tx_sample_valid), 32'd1);
            tx_take(v);
            chk(v == 32'hA500_0000 + 32'(k * 32'h0101), "R2 tx order", v, 32'hA500_0000 + 32'(k * 32'h0101));
        end
        chk(!tx_sample_valid && tx_sample == 0, "R11 empty", tx_sample, 32'd0);
        tx_take(v);
        chk(tx_free == 7'd16, "R11 req on empty ignored", 32'(tx_free), 32'd16);
        chk(tx_overflow, "R10 overflow sticky", 32'(tx_overflow), 32'd1);
        tx_clear = 1'b1; step(); tx_clear = 1'b0;
        chk(!tx_overflow, "R10 tx_clear drops flag", 32'(tx_overflow), 32'd0);

        // R7 R8: receive fill sweep
        for (int k = 0; k <= 16; k++) begin
            for (int lvl = 0; lvl < 4; lvl++) begin
                rx_level = 2'(lvl);
                #0.2;
                chk(rx_attn == exp_attn(lvl, k), "R7 rx_attn", 32'(rx_attn), 32'(exp_attn(lvl, k)));
                chk(rx_irq == exp_attn(lvl, k), "R8 rx_irq", 32'(rx_irq), 32'(exp_attn(lvl, k)));
            end
            step();
            if (k < 16) rx_put(32'h1234_5600 + 32'(k));
        end
        rx_put(32'hFFFF_FFFF); // R10 dropped: full
        for (int k = 0; k < 16; k++) begin
            cpu_read(v);
            chk(v == 32'h1234_5600 + 32'(k), "R2 rx order", v, 32'h1234_5600 + 32'(k));
        end
        cpu_read(v);
        chk(v == 32'd0, "R10 empty read zero", v, 32'd0);
        chk(rx_underflow, "R10 rx_underflow", 32'(rx_underflow), 32'd1);
        rx_clear = 1'b1; step(); rx_clear = 1'b0;
        chk(!rx_underflow, "R10 rx_clear drops flag", 32'(rx_underflow), 32'd0);

        // R2 R3 R4: transmit format x bus size sweep
        for (int f = 0; f < 8; f++) begin
            for (int b = 0; b < 4; b++) begin
                word_fmt = 3'(f); bus_size = 2'(b);
                lo = 16'h9600 | 16'(f << 4) | 16'(b);
                hi = 16'hC300 | 16'(b << 4) | 16'(f);
                cpu_write({hi, lo});
                if (f >= 4) begin
                    tx_take(v);
                    chk(v == ({lo, 16'h0} & bmask(b)), "R3 tx first half", v, {lo, 16'h0} & bmask(b));
                    chk(tx_free == 7'd15, "R3 word kept", 32'(tx_free), 32'd15);
                    tx_take(v);
                    chk(v == ({hi, 16'h0} & bmask(b)), "R3 tx second half", v, {hi, 16'h0} & bmask(b));
                end else begin
                    tx_take(v);
                    chk(v == ({hi, lo} & bmask(b)), "R4 tx mask", v, {hi, lo} & bmask(b));
                end
                chk(tx_free == 7'd16, "R5 word released", 32'(tx_free), 32'd16);
            end
        end

        // R2 R3 R4: receive format x bus size sweep
        for (int f = 0; f < 8; f++) begin
            for (int b = 0; b < 4; b++) begin
                word_fmt = 3'(f); bus_size = 2'(b);
                v = 32'h8E71_4DB2 ^ 32'(f * 32'h0011_0201) ^ 32'(b);
                w = ~v;
                rx_put(v);
                if (f >= 4) begin
                    chk(cpu_rd_data == 32'd0, "R3 rx waits for pair", cpu_rd_data, 32'd0);
                    rx_put(w);
                    cpu_read(v);
                    w = 32'h8E71_4DB2 ^ 32'(f * 32'h0011_0201) ^ 32'(b);
                    chk(v == {(~w & bmask(b)) >> 16 << 16 | ((w & bmask(b)) >> 16)},
                        "R3 rx pair", v, ((~w & bmask(b)) & 32'hFFFF_0000) | ((w & bmask(b)) >> 16));
                end else begin
                    cpu_read(w);
                    chk(w == (v & bmask(b)), "R4 rx mask", w, v & bmask(b));
                end
            end
        end

        // R9: clear priority, isolation, half restart
        word_fmt = 3'd3; bus_size = 2'd2;
        rx_put(32'h0000_1111);
        rx_put(32'h0000_2222);
        cpu_write(32'h1); cpu_write(32'h2); cpu_write(32'h3);
        tx_clear = 1'b1; cpu_wr_en = 1'b1; cpu_wr_data = 32'h4; step();
        tx_clear = 1'b0; cpu_wr_en = 1'b0;
        chk(tx_free == 7'd16, "R9 tx_clear wins over write", 32'(tx_free), 32'd16);
        cpu_read(v);
        chk(v == 32'h0000_1111, "R9 rx untouched by tx_clear", v, 32'h0000_1111);
        rx_clear = 1'b1; rx_sample_valid = 1'b1; rx_sample = 32'h5; step();
        rx_clear = 1'b0; rx_sample_valid = 1'b0;
        chk(cpu_rd_data == 32'd0, "R9 rx_clear wins over push", cpu_rd_data, 32'd0);
        cpu_write(32'h7);
        rx_clear = 1'b1; step(); rx_clear = 1'b0;
        chk(tx_free == 7'd15, "R9 tx untouched by rx_clear", 32'(tx_free), 32'd15);
        tx_clear = 1'b1; step(); tx_clear = 1'b0;
        word_fmt = 3'd4;
        cpu_write(32'hAAAA_BBBB);
        tx_take(v);
        tx_clear = 1'b1; step(); tx_clear = 1'b0;
        cpu_write(32'hCCCC_DDDD);
        chk(tx_sample == 32'hDDDD_0000, "R9 split restarts", tx_sample, 32'hDDDD_0000);
        rx_put(32'h1357_0000);
        rx_clear = 1'b1; step(); rx_clear = 1'b0;
        rx_put(32'h2468_0000);
        rx_put(32'h9BDF_0000);
        cpu_read(v);
        chk(v == 32'h9BDF_2468, "R9 join restarts", v, 32'h9BDF_2468);

        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
        $finish;
    end

endmodule